// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Engine

This engine moves a stream of incoming 32-bit words into memory buffers without help from the processor. Software builds a circular chain of descriptors in memory. Each descriptor has an ownership flag, the base of a data buffer and a link to the next descriptor. Software marks every descriptor as free. It then gives the engine the address of one descriptor and pulses a start input.

From then on the engine works by itself. It reads the three descriptor words through a single-request memory port. It fills the buffer word by word from a valid/ready input stream. When the buffer is complete, it writes the ownership flag back as filled. It then pulses an interrupt once and follows the link to the next descriptor. Because the last link points back to the first descriptor, the walk wraps around.

When the engine reaches a descriptor that is still marked filled, it holds the stream off and polls that descriptor until software frees it. A stop request ends operation, but only between buffers.

Top module: `ring_rx_dma`

## Requirements
- R1: While reset is held and directly after it, `busy`, `irq`, `mem_req` and `in_ready` are all low.
- R2: After a `start` pulse in idle, the first memory access is a read of the descriptor at `desc_base`. The three words of a descriptor sit at byte offsets +0 (ownership flag in bit 0), +4 (buffer base) and +8 (next-descriptor address).
- R3: A descriptor whose flag reads 1 (filled) makes the engine stall. During the stall `in_ready` stays low and the flag word at +0 is read again and again. Once the flag reads 0 (free), the engine continues with that same descriptor.
- R4: Stream words are written, in arrival order, to buffer base + 4*i for i = 0 .. BUF_WORDS-1 (default 128 words, which is 512 bytes). Each write carries the exact stream data.
- R5: After the last data write has been acknowledged, the engine writes the value 1 to the descriptor's +0 word. It writes nothing else to the descriptor.
- R6: The engine gives exactly one interrupt per filled buffer. The interrupt is a single-cycle pulse that comes after the status write has been acknowledged.
- R7: After the interrupt, the next descriptor processed is the one named in the +8 word. The ring therefore wraps from the last node back to the first.
- R8: At most one memory request is outstanding. Every accepted request (read or write) is answered by exactly one `mem_rvalid` cycle before the next request is raised.
- R9: `busy` rises on `start` and stays high until a `stop` pulse is honoured. A stop that arrives during a buffer is honoured only after that buffer's interrupt. A `start` that arrives while busy is ignored.
- R10: `in_ready` is high only while the engine waits for a data word. It is never high together with a memory request or while a response is pending.
- R11: A memory request that has not been granted stays asserted, and its address, write enable and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_base | input | 32 | Byte address of the first descriptor, taken on start |
| start | input | 1 | Begin walking the ring (ignored while busy) |
| stop | input | 1 | Request to halt at the next descriptor boundary |
| in_valid | input | 1 | Stream word available |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Engine accepts a stream word this cycle |
| mem_req | output | 1 | Memory request valid |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Response (read data or write acknowledge) |
| irq | output | 1 | One-cycle pulse per completed buffer |
| busy | output | 1 | Engine active |

## Verification
The bench starts the ring on a descriptor whose successor is still marked filled. A design that skipped the ownership check would overwrite a buffer software still owns. A design that stopped polling would hang, with no further status reads. A start pulse sent during the stall checks that a busy engine does not jump to a new ring.

Stream gaps and random grant/response delays check word order and the placement of the last word. An off-by-one buffer length would shift the scoreboard's expected status write against the data writes. An early status write would fall before the last data acknowledge.

The ring is wrapped back to its first node after software frees that node. A stop is sent mid-buffer, so an engine that stopped at once would leave the buffer short and raise no fourth interrupt.

// File: rtl/rdma_pkg.sv
// Shared types and constants for the descriptor-ring receive engine.
// Assumes byte addressing with 32-bit word alignment.
package rdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_FLAG,
        ST_WT_FLAG,
        ST_RD_BUF,
        ST_WT_BUF,
        ST_RD_LINK,
        ST_WT_LINK,
        ST_FILL,
        ST_WR_DATA,
        ST_WT_DATA,
        ST_WR_FLAG,
        ST_WT_FLAG_ACK,
        ST_NOTIFY
    } rdma_state_e;

    localparam int unsigned OFS_FLAG = 0;
    localparam int unsigned OFS_BUF  = 4;
    localparam int unsigned OFS_LINK = 8;

    localparam logic FLAG_FREE   = 1'b0;
    localparam logic FLAG_FILLED = 1'b1;

endpackage

// File: rtl/rdma_word_ctr.sv
// Word index counter for one buffer fill.
// Clears at the start of each buffer, advances on each acknowledged data
// write and flags the final word. Assumes BUF_WORDS >= 2.
module rdma_word_ctr #(
    parameter int unsigned BUF_WORDS = 128,
    localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    logic [IDX_W-1:0] cnt_q;

    // Count acknowledged words within the current buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx  = cnt_q;
    assign last = (cnt_q == IDX_W'(BUF_WORDS - 1));

endmodule

// File: rtl/rdma_mem_mux.sv
// Decodes the controller state into a memory request.
// Purely combinational. All inputs are registers that hold steady while a
// request waits for its grant.
module rdma_mem_mux
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 7
) (
    input  rdma_state_e       state,
    input  logic [ADDR_W-1:0] cur_desc,
    input  logic [ADDR_W-1:0] buf_base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data_q,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    // Select request kind, address and payload for the current state.
    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = cur_desc;
        wdata = '0;
        unique case (state)
            ST_RD_FLAG: begin
                req  = 1'b1;
                addr = cur_desc + ADDR_W'(OFS_FLAG);
            end
            ST_RD_BUF: begin
                req  = 1'b1;
                addr = cur_desc + ADDR_W'(OFS_BUF);
            end
            ST_RD_LINK: begin
                req  = 1'b1;
                addr = cur_desc + ADDR_W'(OFS_LINK);
            end
            ST_WR_DATA: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = buf_base + ADDR_W'({idx, 2'b00});
                wdata = data_q;
            end
            ST_WR_FLAG: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = cur_desc + ADDR_W'(OFS_FLAG);
                wdata = DATA_W'(FLAG_FILLED);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rdma_ctrl.sv
// Sequencer for the ring walk.
// Fetches a descriptor, polls while it is marked filled, fills its buffer
// one word per memory transaction, marks it filled, pulses the interrupt
// and follows the link. Assumes each accepted request gets one response.
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              start,
    input  logic              stop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              last_word,
    output rdma_state_e       state,
    output logic [ADDR_W-1:0] cur_desc,
    output logic [ADDR_W-1:0] buf_base,
    output logic [DATA_W-1:0] data_q,
    output logic              ctr_clr,
    output logic              ctr_inc,
    output logic              in_ready,
    output logic              irq,
    output logic              busy
);

    rdma_state_e       st_q;
    logic [ADDR_W-1:0] link_q;
    logic              stop_pend_q;

    // Advance the walk and capture descriptor fields and stream words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_desc <= '0;
            buf_base <= '0;
            link_q   <= '0;
            data_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    cur_desc <= desc_base;
                    st_q     <= ST_RD_FLAG;
                end
                ST_RD_FLAG: if (mem_gnt) st_q <= ST_WT_FLAG;
                ST_WT_FLAG: if (mem_rvalid) begin
                    if (mem_rdata[0] == FLAG_FILLED) begin
                        st_q <= stop_pend_q ? ST_IDLE : ST_RD_FLAG;
                    end else begin
                        st_q <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: if (mem_gnt) st_q <= ST_WT_BUF;
                ST_WT_BUF: if (mem_rvalid) begin
                    buf_base <= mem_rdata[ADDR_W-1:0];
                    st_q     <= ST_RD_LINK;
                end
                ST_RD_LINK: if (mem_gnt) st_q <= ST_WT_LINK;
                ST_WT_LINK: if (mem_rvalid) begin
                    link_q <= mem_rdata[ADDR_W-1:0];
                    st_q   <= ST_FILL;
                end
                ST_FILL: if (in_valid) begin
                    data_q <= in_data;
                    st_q   <= ST_WR_DATA;
                end
                ST_WR_DATA: if (mem_gnt) st_q <= ST_WT_DATA;
                ST_WT_DATA: if (mem_rvalid) begin
                    st_q <= last_word ? ST_WR_FLAG : ST_FILL;
                end
                ST_WR_FLAG: if (mem_gnt) st_q <= ST_WT_FLAG_ACK;
                ST_WT_FLAG_ACK: if (mem_rvalid) st_q <= ST_NOTIFY;
                ST_NOTIFY: begin
                    cur_desc <= link_q;
                    st_q     <= stop_pend_q ? ST_IDLE : ST_RD_FLAG;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Remember a stop request until the next descriptor boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q == ST_IDLE) begin
            stop_pend_q <= 1'b0;
        end else if (stop) begin
            stop_pend_q <= 1'b1;
        end
    end

    assign state    = st_q;
    assign ctr_clr  = (st_q == ST_WT_LINK) && mem_rvalid;
    assign ctr_inc  = (st_q == ST_WT_DATA) && mem_rvalid && !last_word;
    assign in_ready = (st_q == ST_FILL);
    assign irq      = (st_q == ST_NOTIFY);
    assign busy     = (st_q != ST_IDLE);

endmodule

// File: rtl/ring_rx_dma.sv
// Top level of the descriptor-ring receive engine.
// Joins the sequencer, the word counter and the request decoder.
// Assumes a memory that answers each accepted request exactly once.
module ring_rx_dma
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BUF_WORDS = 128,
    localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              start,
    input  logic              stop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              irq,
    output logic              busy
);

    rdma_state_e       state;
    logic [ADDR_W-1:0] cur_desc;
    logic [ADDR_W-1:0] buf_base;
    logic [DATA_W-1:0] data_q;
    logic              ctr_clr;
    logic              ctr_inc;
    logic [IDX_W-1:0]  idx;
    logic              last_word;

    rdma_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_base  (desc_base),
        .start      (start),
        .stop       (stop),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .last_word  (last_word),
        .state      (state),
        .cur_desc   (cur_desc),
        .buf_base   (buf_base),
        .data_q     (data_q),
        .ctr_clr    (ctr_clr),
        .ctr_inc    (ctr_inc),
        .in_ready   (in_ready),
        .irq        (irq),
        .busy       (busy)
    );

    rdma_word_ctr #(.BUF_WORDS(BUF_WORDS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .idx   (idx),
        .last  (last_word)
    );

    rdma_mem_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
        .state    (state),
        .cur_desc (cur_desc),
        .buf_base (buf_base),
        .idx      (idx),
        .data_q   (data_q),
        .req      (mem_req),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

endmodule

// File: rtl/rdma_chk.sv
// Protocol checker for the receive engine, bound to the top module.
// Tracks the outstanding-request window from the port handshake alone.
module rdma_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rvalid,
    input logic              in_ready,
    input logic              irq,
    input logic              busy
);

    logic pend_q;

    // Open the window on an accepted request, close it on the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_req && mem_gnt) begin
            pend_q <= 1'b1;
        end else if (mem_rvalid) begin
            pend_q <= 1'b0;
        end
    end

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6
    irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_rvalid));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !in_ready && !irq));

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!mem_req && !pend_q));

endmodule

bind ring_rx_dma rdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .in_ready   (in_ready),
    .irq        (irq),
    .busy       (busy)
);

// File: tb/sim_ring_rx_dma.sv
`timescale 1ns/1ps
module sim_ring_rx_dma;

    localparam int NW = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] desc_base = '0;
    logic        start = 1'b0, stop = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        irq, busy;

    int errors = 0, checks = 0;
    int irq_cnt = 0, flag_wr = 0, poll_cnt = 0, rdy_cnt = 0, idle_req = 0;
    bit first_rd_pending = 0, done = 0;

    typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q[$];
    logic [31:0] mem [0:2047];

    always #4 clk = ~clk;

    ring_rx_dma u0 (
        .clk(clk), .rst_n(rst_n), .desc_base(desc_base), .start(start), .stop(stop),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .irq(irq), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] dval(input int k, input int i);
        return 32'hC0DE_0000 | (k << 12) | i;
    endfunction

    // Memory model and scoreboard monitor, all driven at the falling edge.
    initial begin : memory_model
        bit acc = 0;
        logic [31:0] a_addr = '0, a_wdata = '0, rd_val = '0;
        logic a_we = 0;
        int lat = 0;
        wr_t e;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (acc) begin
                if (a_we) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R4/R5 unexpected write", a_addr, 32'h0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(a_addr == e.a, "R4/R5 write address", a_addr, e.a);
                        chk(a_wdata == e.d, "R4/R5 write data", a_wdata, e.d);
                    end
                    if (a_addr < 32'h200) flag_wr++;
                    mem[a_addr[12:2]] = a_wdata;
                    rd_val = '0;
                end else begin
                    if (first_rd_pending) begin
                        chk(a_addr == 32'h100, "R2 first read address", a_addr, 32'h100);
                        first_rd_pending = 0;
                    end
                    if (a_addr == 32'h110) poll_cnt++;
                    rd_val = mem[a_addr[12:2]];
                end
                lat = 1 + int'($urandom % 2);
            end
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd_val;
                end
            end
            if (irq) begin
                irq_cnt++;
                // R6: one interrupt, after its own status write
                chk(flag_wr == irq_cnt, "R6 irq vs status writes", flag_wr, irq_cnt);
            end
            if (in_ready) rdy_cnt++;
            if (!busy && mem_req) idle_req++;
            mem_gnt = mem_req && (lat == 0) && !mem_rvalid && ($urandom % 4 != 0);
            acc = mem_gnt;
            a_addr = mem_addr; a_we = mem_we; a_wdata = mem_wdata;
        end
    end

    // Driver: queue the expected writes for one buffer, then stream its words.
    task automatic send_buf(input int k, input logic [31:0] desc, input logic [31:0] bbase, input int stop_at);
        bit ok;
        for (int i = 0; i < NW; i++) exp_q.push_back({bbase + 32'(4 * i), dval(k, i)});
        exp_q.push_back({desc, 32'h1});
        for (int i = 0; i < NW; i++) begin
            if (i == stop_at) begin
                stop = 1'b1;
                @(negedge clk);
                stop = 1'b0;
            end
            if (i % 5 == 3) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_data  = dval(k, i);
            in_valid = 1'b1;
            forever begin
                ok = in_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_irqs(input int n);
        for (int t = 0; t < 5000 && irq_cnt < n; t++) @(negedge clk);
        chk(irq_cnt >= n, "R6 interrupt count reached", irq_cnt, n);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        mem[32'h100 >> 2] = 32'h0;  mem[32'h104 >> 2] = 32'h1000; mem[32'h108 >> 2] = 32'h110;
        mem[32'h110 >> 2] = 32'h1;  mem[32'h114 >> 2] = 32'h1400; mem[32'h118 >> 2] = 32'h120;
        mem[32'h120 >> 2] = 32'h0;  mem[32'h124 >> 2] = 32'h1800; mem[32'h128 >> 2] = 32'h100;

        repeat (3) @(negedge clk);
        // R1: quiet while in reset
        chk(!busy && !irq && !mem_req && !in_ready, "R1 outputs in reset",
            {busy, irq, mem_req, in_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !irq && !mem_req && !in_ready, "R1 outputs after reset",
            {busy, irq, mem_req, in_ready}, 32'h0);

        desc_base = 32'h100;
        first_rd_pending = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9 busy after start", busy, 1);

        send_buf(0, 32'h100, 32'h1000, -1);
        wait_irqs(1);
        chk(mem[32'h100 >> 2] == 32'h1, "R5 first flag written", mem[32'h100 >> 2], 1);
        chk(first_rd_pending == 0, "R2 a read was issued", first_rd_pending, 0);

        // R3: next descriptor is still filled; the engine must wait and poll
        repeat (4) @(negedge clk);
        poll_cnt = 0; rdy_cnt = 0;
        desc_base = 32'h120;
        start = 1'b1;              // R9: ignored while busy
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        chk(rdy_cnt == 0, "R3 no ready while stalled", rdy_cnt, 0);
        chk(poll_cnt >= 2, "R3 flag re-read while stalled", poll_cnt, 2);
        chk(irq_cnt == 1, "R3 no interrupt while stalled", irq_cnt, 1);
        chk(busy, "R9 busy while stalled", busy, 1);
        mem[32'h110 >> 2] = 32'h0;

        send_buf(1, 32'h110, 32'h1400, -1);
        mem[32'h100 >> 2] = 32'h0;  // software frees the first node again
        send_buf(2, 32'h120, 32'h1800, -1);
        wait_irqs(3);
        chk(mem[32'h120 >> 2] == 32'h1, "R5 third flag written", mem[32'h120 >> 2], 1);

        // R7: ring wraps to the first node; R9: stop mid-buffer
        send_buf(3, 32'h100, 32'h1000, 10);
        wait_irqs(4);
        repeat (3) @(negedge clk);
        chk(!busy, "R9 busy low after stop", busy, 0);
        idle_req = 0;
        repeat (50) @(negedge clk);
        chk(idle_req == 0, "R9 no requests after stop", idle_req, 0);
        chk(irq_cnt == 4, "R6 total interrupts", irq_cnt, 4);
        chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
        chk(mem[(32'h1000 >> 2) + NW - 1] == dval(3, NW - 1), "R7 wrapped buffer last word",
            mem[(32'h1000 >> 2) + NW - 1], dval(3, NW - 1));
        chk(mem[32'h100 >> 2] == 32'h1, "R7 wrapped node flagged", mem[32'h100 >> 2], 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule